// File: doc/BRIEF.md
# FIFO Threshold Offset Programmer

This block holds the two threshold values that a FIFO uses to raise its almost-empty and almost-full warnings. It sits next to the FIFO write port and shares its write clock, write enable and data bus. While the load control is low, write cycles go into the threshold registers instead of the storage array. While it is high, the write enable passes through to the array as an ordinary FIFO write.

The level of the load control during master reset does two things. It picks the default thresholds, and it fixes how new thresholds get in. A low level gives 127 for both thresholds and word-parallel loading from the data bus. A high level gives 1023 for both and bit-serial loading through a serial data pin qualified by a serial enable. That choice holds until the next master reset. A bus-width input selects wide operation, with 13-bit thresholds written as whole words, or narrow operation, with 14-bit thresholds split into an 8-bit low part and a 6-bit high part. The stored values can always be read back as words through a read pointer that is separate from the write pointer.

A loading sequence may stop at any point so that normal FIFO writes can pass, and it then picks up where it stopped. A partial reset freezes all threshold accesses while it is low but keeps every value and pointer.

Top module: `fifo_offset_loader`

## Requirements
- R1: On the clock edges where master reset `mrst_n` is low, the level of `load_n_i` is sampled. Low sets both thresholds to 127 and selects parallel loading. High sets both to 1023 and selects serial loading. Read data resets to 0.
- R2: The loading method stays fixed until the next master reset. In serial mode, parallel write cycles change nothing. In parallel mode, serial bits change nothing.
- R3: In wide parallel loading, each edge with `load_n_i` and `wen_n_i` both low writes `din_i[12:0]` (bit 13 cleared). The first such edge writes the empty threshold, the second writes the full threshold, and the third returns to the empty threshold. Bus bits 17..13 are ignored.
- R4: In narrow parallel loading, qualifying edges write in this order, then wrap to the first: empty bits 7..0 from `din_i[7:0]`, empty bits 13..8 from `din_i[5:0]`, full bits 7..0, full bits 13..8.
- R5: In wide serial loading, each edge with `load_n_i` and `sen_n_i` both low takes one bit from `si_i`. The first 13 bits go to the empty threshold, LSB first, and the next 13 go to the full threshold, LSB first. That makes 26 bits per sequence.
- R6: In narrow serial loading, the sequence is 28 bits. The first 14 go to the empty threshold, LSB first: its 8-bit low part, then its 6-bit high part. The full threshold follows in the same way.
- R7: `flag_valid_o` is high after reset and always high in parallel mode. In serial mode it falls after the first bit of a sequence and rises again only once the last bit of the sequence has been taken.
- R8: With `sen_n_i` high, or with `load_n_i` high, no serial bit is taken. The sequence position is kept and resumes with the next qualifying edge.
- R9: `fifo_wr_o` is high exactly when `load_n_i` is high, `wen_n_i` is low and neither reset is active. Such FIFO writes leave the thresholds unchanged.
- R10: An edge with `rd_stb_i` high and `load_n_i` low places the register at the read pointer on `rdata_o`, zero-extended, and moves the read pointer on in the same order as parallel writes. In wide mode the register is a whole 13-bit threshold. In narrow mode it is the 8-bit low part or the 6-bit high part.
- R11: When a threshold write (parallel or serial) and a read are requested in the same cycle, the write is performed and the read is ignored: `rdata_o` and the read pointer do not change.
- R12: While `prst_n` is low, no threshold write or read takes place and `fifo_wr_o` is low. Thresholds and both pointers keep their values across the partial reset.
- R13: Master reset returns both the write pointer and the read pointer to the empty threshold's low part, and clears the serial bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low, freezes threshold access |
| narrow_i | input | 1 | 1 = narrow (split threshold) mode, 0 = wide mode; static |
| load_n_i | input | 1 | Threshold access select, active low; mode select during master reset |
| wen_n_i | input | 1 | Write enable, active low |
| sen_n_i | input | 1 | Serial bit enable, active low |
| si_i | input | 1 | Serial threshold data |
| rd_stb_i | input | 1 | Threshold read strobe, active high |
| din_i | input | 18 | FIFO write data bus |
| fifo_wr_o | output | 1 | Write strobe to the FIFO storage array |
| empty_ofs_o | output | 14 | Current almost-empty threshold |
| full_ofs_o | output | 14 | Current almost-full threshold |
| flag_valid_o | output | 1 | Thresholds are complete and usable |
| rdata_o | output | 18 | Threshold readback data |

## Verification
The hardest state to reach is a serial sequence that has been interrupted part-way. Reaching it means holding a partly shifted bit position across stall cycles and ordinary FIFO writes, and then finishing with the right bit count. The stimulus shifts a few bits and then inserts a FIFO write and an idle cycle with serial enable high. It also inserts a parallel-style write that must be ignored. The bench checks that the outputs do not move during these cycles and that the final thresholds match the intended values with no shift. The write-versus-read collision and the partial-reset freeze are set up the same way, by lining both accesses up on a single edge.

// File: rtl/ofl_pkg.sv
package ofl_pkg;

    // register index shared by write and read pointers: bit 1 selects the
    // threshold (0 empty, 1 full), bit 0 selects the high part in narrow mode
    typedef enum logic [1:0] {
        IDX_E_LO = 2'd0,
        IDX_E_HI = 2'd1,
        IDX_F_LO = 2'd2,
        IDX_F_HI = 2'd3
    } ofs_idx_e;

    function automatic ofs_idx_e next_idx(ofs_idx_e cur, logic narrow);
        ofs_idx_e nxt;
        if (narrow) begin
            nxt = ofs_idx_e'(cur + 2'd1);
        end else begin
            nxt = cur[1] ? IDX_E_LO : IDX_F_LO;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/ofl_wr_ctrl.sv
module ofl_wr_ctrl
    import ofl_pkg::*;
#(
    parameter int OFS_W = 14,
    parameter int CNT_W = $clog2(2 * OFS_W)
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             active,
    input  logic             serial_mode,
    input  logic             narrow,
    input  logic             load_n,
    input  logic             wen_n,
    input  logic             sen_n,
    output logic             par_we,
    output ofs_idx_e         par_idx,
    output logic             ser_we,
    output logic [CNT_W-1:0] ser_pos,
    output logic             ser_busy
);

    localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(2 * OFS_W - 1);
    localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(2 * (OFS_W - 1) - 1);

    typedef struct packed {
        ofs_idx_e         idx;
        logic [CNT_W-1:0] pos;
    } wr_state_t;

    wr_state_t state_d, state_q;
    logic [CNT_W-1:0] last_pos;

    always_comb begin
        par_we   = active && !serial_mode && !load_n && !wen_n;
        ser_we   = active &&  serial_mode && !load_n && !sen_n;
        last_pos = narrow ? LAST_NARROW : LAST_WIDE;
        state_d  = state_q;
        if (par_we) begin
            state_d.idx = next_idx(state_q.idx, narrow);
        end
        if (ser_we) begin
            state_d.pos = (state_q.pos == last_pos) ? '0 : state_q.pos + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            state_q <= '{idx: IDX_E_LO, pos: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign par_idx  = state_q.idx;
    assign ser_pos  = state_q.pos;
    assign ser_busy = (state_q.pos != '0);

endmodule

// File: rtl/ofl_rd_ctrl.sv
module ofl_rd_ctrl
    import ofl_pkg::*;
#(
    parameter int OFS_W = 14,
    parameter int LSB_W = 8,
    parameter int BUS_W = 18
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             rd_req,
    input  logic             narrow,
    input  logic [OFS_W-1:0] empty_ofs,
    input  logic [OFS_W-1:0] full_ofs,
    output logic [BUS_W-1:0] rdata
);

    localparam int WIDE_W = OFS_W - 1;

    typedef struct packed {
        ofs_idx_e         idx;
        logic [BUS_W-1:0] data;
    } rd_state_t;

    rd_state_t state_d, state_q;
    logic [OFS_W-1:0] sel_ofs;
    logic [BUS_W-1:0] sel_word;

    always_comb begin
        sel_ofs = state_q.idx[1] ? full_ofs : empty_ofs;
        if (narrow) begin
            sel_word = state_q.idx[0] ? BUS_W'(sel_ofs[OFS_W-1:LSB_W])
                                      : BUS_W'(sel_ofs[LSB_W-1:0]);
        end else begin
            sel_word = BUS_W'(sel_ofs[WIDE_W-1:0]);
        end
        state_d = state_q;
        if (rd_req) begin
            state_d.data = sel_word;
            state_d.idx  = next_idx(state_q.idx, narrow);
        end
    end

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            state_q <= '{idx: IDX_E_LO, data: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata = state_q.data;

endmodule

// File: rtl/fifo_offset_loader.sv
module fifo_offset_loader
    import ofl_pkg::*;
#(
    parameter int OFS_W   = 14,
    parameter int LSB_W   = 8,
    parameter int BUS_W   = 18,
    parameter int DEF_PAR = 127,
    parameter int DEF_SER = 1023
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             narrow_i,
    input  logic             load_n_i,
    input  logic             wen_n_i,
    input  logic             sen_n_i,
    input  logic             si_i,
    input  logic             rd_stb_i,
    input  logic [BUS_W-1:0] din_i,
    output logic             fifo_wr_o,
    output logic [OFS_W-1:0] empty_ofs_o,
    output logic [OFS_W-1:0] full_ofs_o,
    output logic             flag_valid_o,
    output logic [BUS_W-1:0] rdata_o
);

    localparam int MSB_W = OFS_W - LSB_W;
    localparam int WIDE_W = OFS_W - 1;
    localparam int CNT_W = $clog2(2 * OFS_W);
    localparam int IX_W = $clog2(OFS_W);

    typedef struct packed {
        logic             serial;
        logic [OFS_W-1:0] empty;
        logic [OFS_W-1:0] full;
    } ofs_state_t;

    ofs_state_t state_d, state_q;

    logic             par_we, ser_we, ser_busy, rd_req, serial_mode;
    ofs_idx_e         par_idx;
    logic [CNT_W-1:0] ser_pos, field_w, full_pos;
    logic             unused_din;

    assign serial_mode = state_q.serial;
    assign unused_din  = ^din_i[BUS_W-1:WIDE_W];

    ofl_wr_ctrl #(.OFS_W(OFS_W), .CNT_W(CNT_W)) u_wr (
        .clk         (clk),
        .mrst_n      (mrst_n),
        .active      (prst_n),
        .serial_mode (serial_mode),
        .narrow      (narrow_i),
        .load_n      (load_n_i),
        .wen_n       (wen_n_i),
        .sen_n       (sen_n_i),
        .par_we      (par_we),
        .par_idx     (par_idx),
        .ser_we      (ser_we),
        .ser_pos     (ser_pos),
        .ser_busy    (ser_busy)
    );

    // writes take priority over reads in the same cycle
    assign rd_req = prst_n && rd_stb_i && !load_n_i && !par_we && !ser_we;

    ofl_rd_ctrl #(.OFS_W(OFS_W), .LSB_W(LSB_W), .BUS_W(BUS_W)) u_rd (
        .clk       (clk),
        .mrst_n    (mrst_n),
        .rd_req    (rd_req),
        .narrow    (narrow_i),
        .empty_ofs (state_q.empty),
        .full_ofs  (state_q.full),
        .rdata     (rdata_o)
    );

    always_comb begin
        state_d  = state_q;
        field_w  = narrow_i ? CNT_W'(OFS_W) : CNT_W'(WIDE_W);
        full_pos = ser_pos - field_w;
        if (par_we) begin
            unique case (par_idx)
                IDX_E_LO: begin
                    if (narrow_i) state_d.empty[LSB_W-1:0] = din_i[LSB_W-1:0];
                    else          state_d.empty = {1'b0, din_i[WIDE_W-1:0]};
                end
                IDX_E_HI: state_d.empty[OFS_W-1:LSB_W] = din_i[MSB_W-1:0];
                IDX_F_LO: begin
                    if (narrow_i) state_d.full[LSB_W-1:0] = din_i[LSB_W-1:0];
                    else          state_d.full = {1'b0, din_i[WIDE_W-1:0]};
                end
                IDX_F_HI: state_d.full[OFS_W-1:LSB_W] = din_i[MSB_W-1:0];
                default: ;
            endcase
        end
        if (ser_we) begin
            if (ser_pos < field_w) state_d.empty[ser_pos[IX_W-1:0]] = si_i;
            else                   state_d.full[full_pos[IX_W-1:0]] = si_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            state_q.serial <= load_n_i;
            state_q.empty  <= load_n_i ? OFS_W'(DEF_SER) : OFS_W'(DEF_PAR);
            state_q.full   <= load_n_i ? OFS_W'(DEF_SER) : OFS_W'(DEF_PAR);
        end else begin
            state_q <= state_d;
        end
    end

    assign empty_ofs_o  = state_q.empty;
    assign full_ofs_o   = state_q.full;
    assign flag_valid_o = !state_q.serial || !ser_busy;
    assign fifo_wr_o    = mrst_n && prst_n && load_n_i && !wen_n_i;

endmodule

// File: rtl/fifo_offset_loader_chk.sv
module fifo_offset_loader_chk #(
    parameter int OFS_W   = 14,
    parameter int BUS_W   = 18,
    parameter int DEF_PAR = 127,
    parameter int DEF_SER = 1023
) (
    input logic             clk,
    input logic             mrst_n,
    input logic             prst_n,
    input logic             load_n_i,
    input logic             wen_n_i,
    input logic             sen_n_i,
    input logic             rd_stb_i,
    input logic             fifo_wr_o,
    input logic [OFS_W-1:0] empty_ofs_o,
    input logic [OFS_W-1:0] full_ofs_o,
    input logic             flag_valid_o,
    input logic [BUS_W-1:0] rdata_o,
    input logic             serial_mode
);

    // R1: defaults match the latched method on reset release
    assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (!mrst_n)
        $rose(mrst_n) |-> (empty_ofs_o == (serial_mode ? OFS_W'(DEF_SER) : OFS_W'(DEF_PAR)))
                       && (full_ofs_o  == (serial_mode ? OFS_W'(DEF_SER) : OFS_W'(DEF_PAR))));

    // R2: the method does not change outside master reset
    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!mrst_n)
        mrst_n |=> $stable(serial_mode));

    // R7: valid only falls after a serial bit was accepted
    assert_valid_fall_R7: assert property (@(posedge clk) disable iff (!mrst_n)
        $fell(flag_valid_o) |-> $past(!load_n_i && !sen_n_i && prst_n));

    // R9: FIFO writes leave the thresholds alone
    assert_fifo_wr_R9: assert property (@(posedge clk) disable iff (!mrst_n)
        fifo_wr_o |=> $stable(empty_ofs_o) && $stable(full_ofs_o));

    // R11: a parallel write beats a read in the same cycle
    assert_wr_prio_R11: assert property (@(posedge clk) disable iff (!mrst_n)
        (rd_stb_i && !load_n_i && !wen_n_i && !serial_mode && prst_n) |=> $stable(rdata_o));

    // R12: partial reset freezes the thresholds
    assert_prst_hold_R12: assert property (@(posedge clk) disable iff (!mrst_n)
        !prst_n |=> $stable(empty_ofs_o) && $stable(full_ofs_o) && $stable(rdata_o));

endmodule

bind fifo_offset_loader fifo_offset_loader_chk #(
    .OFS_W(OFS_W), .BUS_W(BUS_W), .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER)
) u_chk (
    .clk          (clk),
    .mrst_n       (mrst_n),
    .prst_n       (prst_n),
    .load_n_i     (load_n_i),
    .wen_n_i      (wen_n_i),
    .sen_n_i      (sen_n_i),
    .rd_stb_i     (rd_stb_i),
    .fifo_wr_o    (fifo_wr_o),
    .empty_ofs_o  (empty_ofs_o),
    .full_ofs_o   (full_ofs_o),
    .flag_valid_o (flag_valid_o),
    .rdata_o      (rdata_o),
    .serial_mode  (serial_mode)
);

// File: tb/fifo_offset_loader_tb.sv
`timescale 1ns/1ps
module fifo_offset_loader_tb;

    logic        clk = 1'b0;
    logic        mrst_n = 1'b0, prst_n = 1'b1, narrow = 1'b0;
    logic        load_n = 1'b0, wen_n = 1'b1, sen_n = 1'b1, si = 1'b0, rd_stb = 1'b0;
    logic [17:0] din = '0;
    logic        fifo_wr, flag_valid;
    logic [13:0] empty_ofs, full_ofs;
    logic [17:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fifo_offset_loader u_dut (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .narrow_i(narrow),
        .load_n_i(load_n), .wen_n_i(wen_n), .sen_n_i(sen_n), .si_i(si),
        .rd_stb_i(rd_stb), .din_i(din), .fifo_wr_o(fifo_wr),
        .empty_ofs_o(empty_ofs), .full_ofs_o(full_ofs),
        .flag_valid_o(flag_valid), .rdata_o(rdata)
    );

    // {load_n, wen_n, rd, din[17:0], exp_empty[13:0], exp_full[13:0], exp_rdata[17:0]}
    localparam logic [66:0] VEC [0:7] = '{
        {1'b0, 1'b0, 1'b0, 18'h00155, 14'h0155, 14'h007F, 18'h00000},
        {1'b0, 1'b0, 1'b0, 18'h03A0F, 14'h0155, 14'h1A0F, 18'h00000},
        {1'b0, 1'b0, 1'b0, 18'h00007, 14'h0007, 14'h1A0F, 18'h00000},
        {1'b0, 1'b1, 1'b1, 18'h00000, 14'h0007, 14'h1A0F, 18'h00007},
        {1'b1, 1'b0, 1'b0, 18'h01234, 14'h0007, 14'h1A0F, 18'h00007},
        {1'b0, 1'b1, 1'b1, 18'h00000, 14'h0007, 14'h1A0F, 18'h01A0F},
        {1'b0, 1'b0, 1'b1, 18'h00022, 14'h0007, 14'h0022, 18'h01A0F},
        {1'b0, 1'b1, 1'b1, 18'h00000, 14'h0007, 14'h0022, 18'h00007}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        load_n = 1'b1; wen_n = 1'b1; sen_n = 1'b1; rd_stb = 1'b0;
    endtask

    task automatic mreset(logic ld, logic nar);
        mrst_n = 1'b0; load_n = ld; narrow = nar; wen_n = 1'b1; sen_n = 1'b1; rd_stb = 1'b0;
        tick(); tick();
        mrst_n = 1'b1; idle();
    endtask

    task automatic pwr(logic [17:0] d);
        load_n = 1'b0; wen_n = 1'b0; din = d;
        tick(); idle();
    endtask

    task automatic sbit(logic b);
        load_n = 1'b0; sen_n = 1'b0; si = b;
        tick(); idle();
    endtask

    task automatic rd();
        load_n = 1'b0; rd_stb = 1'b1;
        tick(); idle();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [12:0] we_e, we_f;
        logic [13:0] nr_e, nr_f, held;

        // R1 parallel defaults, R10 readback reset value
        mreset(1'b0, 1'b0);
        chk("R1 empty default parallel", empty_ofs, 14'd127);
        chk("R1 full default parallel", full_ofs, 14'd127);
        chk("R1 rdata reset", rdata, 0);
        chk("R7 valid after reset", flag_valid, 1);

        // table: R3 wide parallel order, R9 FIFO write, R10 readback, R11 priority
        for (int i = 0; i < 8; i++) begin
            load_n = VEC[i][66]; wen_n = VEC[i][65]; rd_stb = VEC[i][64]; din = VEC[i][63:46];
            tick(); idle();
            chk("R3/R10/R11 vec empty", empty_ofs, VEC[i][45:32]);
            chk("R3/R10/R11 vec full", full_ofs, VEC[i][31:18]);
            chk("R10/R11 vec rdata", rdata, VEC[i][17:0]);
        end

        // R2 serial bit in parallel mode is ignored
        sbit(1'b1);
        chk("R2 serial ignored in parallel", empty_ofs, 14'h0007);
        chk("R7 valid in parallel mode", flag_valid, 1);

        // R12 partial reset freezes access, pointer kept
        mreset(1'b0, 1'b0);
        pwr(18'h00100);
        prst_n = 1'b0; load_n = 1'b0; wen_n = 1'b0; din = 18'h00AAA;
        #1 chk("R12 fifo_wr low in partial reset", fifo_wr, 0);
        tick(); idle();
        chk("R12 full frozen", full_ofs, 14'd127);
        chk("R12 empty frozen", empty_ofs, 14'h0100);
        prst_n = 1'b1;
        pwr(18'h00055);
        chk("R12 pointer kept", full_ofs, 14'h0055);

        // R13 master reset returns pointer to empty
        mreset(1'b0, 1'b0);
        pwr(18'h00011);
        chk("R13 write pointer at empty", empty_ofs, 14'h0011);
        chk("R13 full untouched", full_ofs, 14'd127);
        rd();
        chk("R13 read pointer at empty", rdata, 18'h00011);

        // R4 narrow parallel
        mreset(1'b0, 1'b1);
        pwr(18'h001AB); pwr(18'h001F5); pwr(18'h00012); pwr(18'h00107);
        chk("R4 narrow empty", empty_ofs, 14'h35AB);
        chk("R4 narrow full", full_ofs, 14'h0712);
        pwr(18'h00044);
        chk("R4 narrow wrap", empty_ofs, 14'h3544);
        rd(); chk("R10 narrow read e lo", rdata, 18'h044);
        rd(); chk("R10 narrow read e hi", rdata, 18'h035);
        rd(); chk("R10 narrow read f lo", rdata, 18'h012);
        rd(); chk("R10 narrow read f hi", rdata, 18'h007);
        rd(); chk("R10 narrow read wrap", rdata, 18'h044);

        // R5 wide serial with interruptions (R8, R9, R2)
        mreset(1'b1, 1'b0);
        chk("R1 empty default serial", empty_ofs, 14'd1023);
        chk("R1 full default serial", full_ofs, 14'd1023);
        we_e = 13'h0A5C; we_f = 13'h1234;
        sbit(we_e[0]);
        chk("R7 valid low mid sequence", flag_valid, 0);
        for (int b = 1; b < 5; b++) sbit(we_e[b]);
        held = empty_ofs;
        load_n = 1'b1; wen_n = 1'b0; din = 18'h3FFFF;
        #1 chk("R9 fifo write passes", fifo_wr, 1);
        tick(); idle();
        load_n = 1'b0; sen_n = 1'b1; wen_n = 1'b0; si = 1'b1; din = 18'h3FFFF;
        tick(); idle();
        chk("R8/R2 stall holds empty", empty_ofs, held);
        chk("R7 valid still low", flag_valid, 0);
        for (int b = 5; b < 13; b++) sbit(we_e[b]);
        for (int b = 0; b < 13; b++) sbit(we_f[b]);
        chk("R5 wide serial empty", empty_ofs, {1'b0, we_e});
        chk("R5 wide serial full", full_ofs, {1'b0, we_f});
        chk("R7 valid after full sequence", flag_valid, 1);
        rd(); chk("R10 serial-mode read empty", rdata, {5'b0, we_e});
        rd(); chk("R10 serial-mode read full", rdata, {5'b0, we_f});

        // R6 narrow serial
        mreset(1'b1, 1'b1);
        nr_e = 14'h2A5C; nr_f = 14'h3123;
        for (int b = 0; b < 14; b++) sbit(nr_e[b]);
        chk("R7 valid low at half sequence", flag_valid, 0);
        for (int b = 0; b < 14; b++) sbit(nr_f[b]);
        chk("R6 narrow serial empty", empty_ofs, nr_e);
        chk("R6 narrow serial full", full_ofs, nr_f);
        chk("R7 valid after narrow sequence", flag_valid, 1);
        // R11 serial write beats read
        load_n = 1'b0; sen_n = 1'b0; si = 1'b0; rd_stb = 1'b1;
        tick(); idle();
        chk("R11 read ignored on serial write", rdata, 18'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule